// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Protection

This block is a slave on a two-wire serial bus (SCL clock, SDA data), fronting a 4096-byte storage array held as a synchronous register file. The two bus lines are sampled against a faster system clock. Each line passes through a spike filter, and START and STOP conditions are then recognised from the filtered levels. The slave answers a control byte that carries a fixed device code and three chip-select bits, which must equal the `strap_i` inputs. It then accepts a 12-bit word address sent as two bytes. It supports byte and sequential writes, and random, current-address and sequential reads.

A write-protect input blocks every store to the array and leaves reads unchanged. The slave never drives SDA high. It only asserts `sda_oe_o`, which means "pull SDA low", and the pull-up sits outside the block. An unmatched control byte, a master NACK, a STOP or a repeated START returns the slave to idle or to control-byte reception. The address pointer is kept across these events.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, and whenever the slave is idle, `sda_oe_o` is 0 (SDA released).
- R2: A control byte is acknowledged only if bits 7:4 are 4'b1010 and bits 3:1 equal `strap_i`. Bit 0 set to 1 means read and 0 means write. On a mismatch the slave does not acknowledge and ignores all bus traffic until the next START.
- R3: A write sends the high address byte first, of which bits 3:0 give address bits 11:8, then the low address byte. Each following data byte is acknowledged, stored at the pointer, and the pointer advances by one.
- R4: While `wprot_i` is 1, write data bytes are still acknowledged but the array is not modified. Reads are unaffected.
- R5: After an address is set in a write and a repeated START is sent with a read control byte, the slave returns the byte at that address.
- R6: The pointer advances after every byte read or written and wraps from 0xFFF to 0x000, for reads and for writes.
- R7: A read that begins without an address phase returns the byte that follows the last byte accessed.
- R8: A master NACK after a read byte ends the read. The slave releases SDA and does not drive it on later clocks until a new START.
- R9: `sda_oe_o` changes only while the filtered SCL is low, except when a START or STOP forces a release.
- R10: A pulse on SCL or SDA that lasts fewer than 3 system-clock samples does not change the filtered level.
- R11: A STOP at any point returns the slave to idle. A byte sent afterwards without a START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| strap_i | input | 3 | Chip-select straps compared with control byte bits 3:1 |
| wprot_i | input | 1 | 1 blocks all array writes |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Every bus edge reaches the control logic about six system clocks after it appears on the pins. That delay is two synchroniser stages, a three-sample filter window and the filtered-level register. One more register then updates `sda_oe_o`. The bench holds each SCL quarter phase for 16 system clocks and changes SDA only in the middle of the low phase. It samples the bus in the middle of the high phase and again just before the falling edge, so acknowledge and data bits are read long after they have settled. Writes are confirmed by reading them back in later transactions, never by looking inside the array.

// File: rtl/twi_eeprom_pkg.sv
`timescale 1ns/1ps
package twi_eeprom_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } twi_state_e;
endpackage

// File: rtl/twi_glitch_filter.sv
`timescale 1ns/1ps
module twi_glitch_filter #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]        sync_q;
  logic [STAGES-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[STAGES-2:0], sync_q[1]};
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end

  a_r10_rise_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_o) |-> $past(&hist_q));
  a_r10_fall_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_o) |-> $past(~|hist_q));
endmodule

// File: rtl/twi_bus_events.sv
`timescale 1ns/1ps
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
  assign scl_rise_o = ~scl_q & scl_f_i;
  assign scl_fall_o = scl_q & ~scl_f_i;

  a_r9_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
endmodule

// File: rtl/twi_mem_array.sv
`timescale 1ns/1ps
module twi_mem_array #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/twi_slave_core.sv
`timescale 1ns/1ps
module twi_slave_core
  import twi_eeprom_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_lvl_i,
  input  logic          sda_lvl_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic [2:0]    strap_i,
  input  logic          wprot_i,
  input  logic [7:0]    rd_data_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] ptr_o,
  output logic          sda_oe_o
);
  localparam int HB = AW - 8;

  twi_state_e    st_q, nxt_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    shreg_q, out_q;
  logic [AW-1:0] ptr_q;
  logic          mack_q;

  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      out_q     <= '0;
      ptr_q     <= '0;
      mack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      we_o      <= 1'b0;
      waddr_o   <= '0;
      wdata_o   <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st_q      <= ST_CTRL;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        st_q      <= ST_IDLE;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (st_q == ST_RDAT) begin
        if (scl_rise_i) begin
          if (bit_cnt_q == 4'd8) begin
            mack_q    <= ~sda_lvl_i;
            bit_cnt_q <= 4'd9;
          end else if (bit_cnt_q < 4'd8) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
        end else if (scl_fall_i) begin
          if (bit_cnt_q < 4'd8) begin
            sda_oe_o <= ~out_q[3'(4'd7 - bit_cnt_q)];
          end else if (bit_cnt_q == 4'd8) begin
            sda_oe_o <= 1'b0;           // master ack slot
            ptr_q    <= ptr_q + 1'b1;
          end else if (mack_q) begin
            out_q     <= rd_data_i;
            sda_oe_o  <= ~rd_data_i[7];
            bit_cnt_q <= '0;
          end else begin
            st_q      <= ST_IDLE;
            bit_cnt_q <= '0;
          end
        end
      end else if (st_q != ST_IDLE) begin
        if (scl_rise_i && bit_cnt_q < 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_lvl_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
          bit_cnt_q <= 4'd9;
          unique case (st_q)
            ST_CTRL: begin
              if (shreg_q[7:4] == DEV_CODE && shreg_q[3:1] == strap_i) begin
                sda_oe_o <= 1'b1;
                nxt_q    <= shreg_q[0] ? ST_RDAT : ST_AHI;
              end else begin
                sda_oe_o <= 1'b0;
                nxt_q    <= ST_IDLE;
              end
            end
            ST_AHI: begin
              ptr_q[AW-1:8] <= shreg_q[HB-1:0];
              sda_oe_o      <= 1'b1;
              nxt_q         <= ST_ALO;
            end
            ST_ALO: begin
              ptr_q[7:0] <= shreg_q;
              sda_oe_o   <= 1'b1;
              nxt_q      <= ST_WDAT;
            end
            ST_WDAT: begin
              we_o     <= ~wprot_i;
              waddr_o  <= ptr_q;
              wdata_o  <= shreg_q;
              ptr_q    <= ptr_q + 1'b1;
              sda_oe_o <= 1'b1;
              nxt_q    <= ST_WDAT;
            end
            default: begin
              sda_oe_o <= 1'b0;
              nxt_q    <= ST_IDLE;
            end
          endcase
        end else if (scl_fall_i && bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
          st_q      <= nxt_q;
          if (nxt_q == ST_RDAT) begin
            out_q    <= rd_data_i;
            sda_oe_o <= ~rd_data_i[7];
          end else begin
            sda_oe_o <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  a_r9_oe_holds_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl_i && !start_i && !stop_i) |=> $stable(sda_oe_o));
  a_r4_wp_blocks_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> !$past(wprot_i));
  a_r3_bit_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd9);
  a_r11_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE));
endmodule

// File: rtl/twi_eeprom_slave.sv
`timescale 1ns/1ps
module twi_eeprom_slave #(
  parameter int AW        = 12,
  parameter int FILT_LEN  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wprot_i,
  output logic       sda_oe_o
);
  logic [1:0]    raw_lines, filt_lines;
  logic          start, stop, scl_rise, scl_fall;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    twi_glitch_filter #(.STAGES(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  twi_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (filt_lines[0]),
    .sda_f_i    (filt_lines[1]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  twi_slave_core #(.AW(AW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (filt_lines[0]),
    .sda_lvl_i  (filt_lines[1]),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .strap_i    (strap_i),
    .wprot_i    (wprot_i),
    .rd_data_i  (mem_rdata),
    .we_o       (mem_we),
    .waddr_o    (mem_waddr),
    .wdata_o    (mem_wdata),
    .ptr_o      (mem_raddr),
    .sda_oe_o   (sda_oe_o)
  );

  twi_mem_array #(.AW(AW), .DW(8)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/twi_eeprom_slave_test.sv
`timescale 1ns/1ps
module twi_eeprom_slave_test;
  localparam int Q = 16;
  localparam logic [7:0] CW = 8'hAA;  // 1010_101_0, straps 3'b101
  localparam logic [7:0] CR = 8'hAB;
  localparam int NV = 4;
  localparam logic [19:0] VEC [NV] = '{
    {12'h000, 8'h5A}, {12'h123, 8'hC3}, {12'h7FE, 8'h01}, {12'hABC, 8'hF0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  bus = m_sda & ~sda_oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  bit   hi_change = 1'b0;

  always #2.5 clk = ~clk;

  twi_eeprom_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(bus),
    .strap_i(strap), .wprot_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic tx(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_sda = b[i];
      if (glitch && i == 4) begin
        repeat (4) @(negedge clk);
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        m_scl = 1'b0;
      end
      wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
    end
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    ack = ~bus;
    wq(); m_scl = 1'b0;
  endtask

  task automatic rx(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
      b[i] = bus;
      repeat (Q - 2) @(negedge clk);
      if (bus != b[i]) hi_change = 1'b1;
      repeat (2) @(negedge clk);
      m_scl = 1'b0;
    end
    wq(); m_sda = ~mack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
    wq(); m_sda = 1'b1;
  endtask

  task automatic set_addr(input logic [11:0] a, output bit ok);
    bit a0, a1, a2;
    bstart(); tx(CW, 1'b0, a0); tx({4'h0, a[11:8]}, 1'b0, a1); tx(a[7:0], 1'b0, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic wr_seq(input logic [11:0] a, input logic [7:0] d0, input logic [7:0] d1,
                        input bit two, output bit ok);
    bit ao, k0, k1;
    set_addr(a, ao);
    tx(d0, 1'b0, k0);
    k1 = 1'b1;
    if (two) tx(d1, 1'b0, k1);
    bstop();
    ok = ao & k0 & k1;
  endtask

  task automatic rd_rand(input logic [11:0] a, output logic [7:0] d);
    bit ao, k;
    set_addr(a, ao);
    bstart(); tx(CR, 1'b0, k); rx(1'b0, d); bstop();
  endtask

  task automatic rd_cur(output logic [7:0] d);
    bit k;
    bstart(); tx(CR, 1'b0, k); rx(1'b0, d); bstop();
  endtask

  initial begin : main
    logic [7:0] d, d2;
    bit ok, ack;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset released", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 idle after reset", int'(sda_oe), 0);

    // vector table: write each, then read each back by random read
    for (int v = 0; v < NV; v++) begin
      wr_seq(VEC[v][19:8], VEC[v][7:0], 8'h00, 1'b0, ok);
      chk(ok, "R3 write acked", int'(ok), 1);
    end
    for (int v = 0; v < NV; v++) begin
      rd_rand(VEC[v][19:8], d);
      chk(d == VEC[v][7:0], "R5 random read", int'(d), int'(VEC[v][7:0]));
    end

    // sequential write, then current-address reads
    wr_seq(12'h200, 8'h10, 8'h11, 1'b1, ok);
    chk(ok, "R3 sequential write acked", int'(ok), 1);
    rd_rand(12'h200, d);
    chk(d == 8'h10, "R5 read 0x200", int'(d), 'h10);
    rd_cur(d);
    chk(d == 8'h11, "R7 current read", int'(d), 'h11);

    // wrap on write and read
    wr_seq(12'hFFF, 8'h3C, 8'h4D, 1'b1, ok);
    chk(ok, "R6 write across wrap acked", int'(ok), 1);
    hi_change = 1'b0;
    set_addr(12'hFFF, ok);
    bstart(); tx(CR, 1'b0, ack); rx(1'b1, d); rx(1'b0, d2); bstop();
    chk(d == 8'h3C, "R6 read 0xFFF", int'(d), 'h3C);
    chk(d2 == 8'h4D, "R6 read wraps to 0x000", int'(d2), 'h4D);
    chk(hi_change == 1'b0, "R9 SDA stable while SCL high", int'(hi_change), 0);

    // write protect
    wp = 1'b1;
    wr_seq(12'h200, 8'hEE, 8'h00, 1'b0, ok);
    chk(ok, "R4 protected data still acked", int'(ok), 1);
    rd_rand(12'h200, d);
    chk(d == 8'h10, "R4 read under protect", int'(d), 'h10);
    wp = 1'b0;
    rd_rand(12'h200, d);
    chk(d == 8'h10, "R4 array unchanged", int'(d), 'h10);

    // strap mismatch
    bstart(); tx(8'hA8, 1'b0, ack);
    chk(!ack, "R2 mismatch not acked", int'(ack), 0);
    tx(8'h00, 1'b0, ack);
    chk(!ack, "R2 ignored until START", int'(ack), 0);
    bstop();
    bstart(); tx(8'hBA, 1'b0, ack);
    chk(!ack, "R2 wrong device code", int'(ack), 0);
    bstop();

    // master NACK ends read
    set_addr(12'h123, ok);
    bstart(); tx(CR, 1'b0, ack); rx(1'b0, d); rx(1'b1, d2); bstop();
    chk(d == 8'hC3, "R8 byte before NACK", int'(d), 'hC3);
    chk(d2 == 8'hFF, "R8 released after NACK", int'(d2), 'hFF);

    // STOP returns idle
    bstart(); tx(CW, 1'b0, ack); bstop();
    m_scl = 1'b0; wq();
    tx(CW, 1'b0, ack);
    chk(!ack, "R11 no ack after STOP", int'(ack), 0);
    m_scl = 1'b1; wq();
    chk(sda_oe == 1'b0, "R1 idle released", int'(sda_oe), 0);

    // SCL spike during control byte
    bstart(); tx(CW, 1'b1, ack);
    chk(ack, "R10 spike filtered, ack", int'(ack), 1);
    tx(8'h03, 1'b0, ok); tx(8'h00, 1'b0, ok); tx(8'h77, 1'b0, ok); bstop();
    rd_rand(12'h300, d);
    chk(d == 8'h77, "R10 data intact", int'(d), 'h77);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule